// File: doc/BRIEF.md
# Two-Wire EEPROM Byte Engine

This block moves one byte at a time between a processor and a two-wire serial EEPROM. The processor has two write strobes. One loads the byte register. The other posts a command word, which carries a 2-bit operation code, a start flag, a stop flag and an acknowledge-enable flag. Writing a valid command is what launches the operation. The engine then generates the serial clock, shifts the byte out or in, most significant bit first, and handles the ninth (acknowledge) clock. It finishes with a busy flag falling and a one-cycle interrupt pulse.

The serial clock is derived from the system clock. Each half period of the serial clock lasts `CLK_HZ / (2*SCL_HZ)` system cycles. The clock only toggles while a byte is in flight and rests high otherwise. The data pin is open-drain: the engine either pulls it low or leaves it released. The incoming line level passes through a configurable synchroniser before it is used. The pins belong to the engine only when a 2-bit pin-mode input selects it. In any other mode, commands and byte loads are ignored and both pins stay at their idle level.

Top module: `twi_byte_engine`

## Requirements
- R1: After reset, busy, irq, ack_ok and sda_pull_o are 0, scl_o is 1 and data_rdata is 0x00.
- R2: A command code of 2'b01 transmits data_rdata most significant bit first on 8 clocks. The line changes only while scl_o is low, so the only data-line edges seen while the clock is high are the requested start and stop conditions.
- R3: After a transmit, ack_ok is 1 if the line was low during the ninth clock and 0 if it was high. During that ninth clock the engine releases the line.
- R4: A command code of 2'b10 samples 8 bits, most significant bit first, while the clock is high. When busy falls, those bits are in data_rdata.
- R5: On the ninth clock of a receive, the engine pulls the line low if ack_en was 1 in the command, and releases it if ack_en was 0.
- R6: busy is 1 from the cycle after an accepted command until the transfer ends. irq is 1 for exactly the single cycle in which busy first reads 0 again.
- R7: Every phase lasts HALF = CLK_HZ/(2*SCL_HZ) cycles, so busy stays high for (18 + 3*start + 3*stop)*HALF cycles.
- R8: With start=1, a start condition (data falls while the clock is high) precedes the byte. With stop=1, a stop condition (data rises while the clock is high) follows it.
- R9: Between transfers scl_o rests at 1.
- R10: Command codes 2'b00 and 2'b11 are ignored. While busy, both command writes and byte loads are ignored.
- R11: When pin_mode is not 2'b01, pins_owned is 0, scl_o is 1, sda_pull_o is 0, and commands and byte loads are ignored.
- R12: A byte load and a transmit command in the same cycle send the newly loaded byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_mode | input | 2 | Pin ownership select; 2'b01 hands the pins to the engine |
| data_we | input | 1 | Byte register write strobe |
| data_wdata | input | 8 | Byte to load |
| ctrl_we | input | 1 | Command write strobe |
| ctrl_cmd | input | 2 | Operation: 01 transmit, 10 receive |
| ctrl_start | input | 1 | Issue a start condition before the byte |
| ctrl_stop | input | 1 | Issue a stop condition after the byte |
| ctrl_ack_en | input | 1 | Receive only: pull low on the ninth clock |
| data_rdata | output | 8 | Byte register contents |
| busy | output | 1 | Operation in progress |
| ack_ok | output | 1 | Slave acknowledged the last transmit |
| irq | output | 1 | One-cycle completion pulse |
| pins_owned | output | 1 | Engine currently owns the pins |
| scl_o | output | 1 | Serial clock level |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_i | input | 1 | Sensed data line level |

## Verification
Two functions can act in the same cycle. A byte load can land in the very edge that accepts a transmit command. A further pair can collide during a transfer, when command and load writes arrive while busy is high. The bench provokes the first case by raising both strobes together. It judges the result by the byte that a bus-level slave model collects on the pins. For the second case it fires new writes in the middle of a transmit. It then checks that the slave still received the original byte, that the busy window kept its exact length, and that the byte register matches the original.

// File: rtl/twi_eng_pkg.sv
package twi_eng_pkg;
   typedef enum logic [3:0] {
      PH_IDLE, PH_S0, PH_S1, PH_S2, PH_LO, PH_HI, PH_P0, PH_P1, PH_P2
   } phase_t;

   localparam logic [1:0] OP_SEND   = 2'b01;
   localparam logic [1:0] OP_FETCH  = 2'b10;
   localparam logic [1:0] PINSEL_ON = 2'b01;
   localparam int         BYTE_W    = 8;
endpackage

// File: rtl/twi_eng_tick.sv
module twi_eng_tick #(
   parameter int HALF = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   logic [CW-1:0] cnt;

   assign tick = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (restart || tick)  cnt <= '0;
      else                       cnt <= cnt + 1'b1;
   end

   // R7
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/twi_eng_sync.sv
module twi_eng_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= {sr[STAGES-2:0], d};
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/twi_eng_seq.sv
module twi_eng_seq
   import twi_eng_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              accept,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_byte,
   input  logic              cmd_rx,
   input  logic              cmd_start,
   input  logic              cmd_stop,
   input  logic              cmd_ack_en,
   input  logic              sda_in,
   output logic              busy,
   output logic              irq,
   output logic              ack_ok,
   output logic [BYTE_W-1:0] byte_q,
   output logic              sda_pull,
   output logic              scl_lvl
);
   phase_t            ph, ph_n;
   logic [3:0]        bidx, bidx_n;
   logic [BYTE_W-1:0] sh, sh_n;
   logic              pull_n, ack_n, done;
   logic              rx_q, stop_q, acken_q;
   logic              rx_n, acken_n;

   assign rx_n    = accept ? cmd_rx     : rx_q;
   assign acken_n = accept ? cmd_ack_en : acken_q;

   always_comb begin
      ph_n   = ph;
      bidx_n = bidx;
      sh_n   = sh;
      ack_n  = ack_ok;
      done   = 1'b0;
      if (load) sh_n = load_byte;
      if (accept) begin
         bidx_n = '0;
         ph_n   = cmd_start ? PH_S0 : PH_LO;
      end else if (tick) begin
         unique case (ph)
            PH_S0: ph_n = PH_S1;
            PH_S1: ph_n = PH_S2;
            PH_S2: ph_n = PH_LO;
            PH_LO: ph_n = PH_HI;
            PH_HI: begin
               if (bidx < 4'd8) begin
                  sh_n   = {sh[BYTE_W-2:0], sda_in};
                  bidx_n = bidx + 4'd1;
                  ph_n   = PH_LO;
               end else begin
                  if (!rx_q) ack_n = !sda_in;
                  ph_n = stop_q ? PH_P0 : PH_IDLE;
                  done = !stop_q;
               end
            end
            PH_P0: ph_n = PH_P1;
            PH_P1: ph_n = PH_P2;
            PH_P2: begin
               ph_n = PH_IDLE;
               done = 1'b1;
            end
            default: ph_n = PH_IDLE;
         endcase
      end

      pull_n = sda_pull;
      if (ph_n != ph) begin
         unique case (ph_n)
            PH_S0, PH_S1, PH_P2: pull_n = 1'b0;
            PH_S2, PH_P0, PH_P1: pull_n = 1'b1;
            PH_LO: begin
               if (bidx_n < 4'd8) pull_n = rx_n ? 1'b0 : !sh_n[BYTE_W-1];
               else               pull_n = rx_n ? acken_n : 1'b0;
            end
            default: pull_n = sda_pull;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         bidx     <= '0;
         sh       <= '0;
         sda_pull <= 1'b0;
         ack_ok   <= 1'b0;
         irq      <= 1'b0;
         rx_q     <= 1'b0;
         stop_q   <= 1'b0;
         acken_q  <= 1'b0;
      end else begin
         ph       <= ph_n;
         bidx     <= bidx_n;
         sh       <= sh_n;
         sda_pull <= pull_n;
         ack_ok   <= ack_n;
         irq      <= done;
         if (accept) begin
            rx_q    <= cmd_rx;
            stop_q  <= cmd_stop;
            acken_q <= cmd_ack_en;
         end
      end
   end

   assign busy    = (ph != PH_IDLE);
   assign byte_q  = sh;
   assign scl_lvl = !(ph == PH_S0 || ph == PH_LO || ph == PH_P0);

   // R6
   irq_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq);
   // R6
   irq_only_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!busy && $past(busy)));
   // R2
   sda_still_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_HI && $past(ph) == PH_HI) |-> $stable(sda_pull));
   // R9
   scl_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> scl_lvl);
endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
   import twi_eng_pkg::*;
#(
   parameter int CLK_HZ      = 10_000_000,
   parameter int SCL_HZ      = 78_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        pin_mode,
   input  logic              data_we,
   input  logic [BYTE_W-1:0] data_wdata,
   input  logic              ctrl_we,
   input  logic [1:0]        ctrl_cmd,
   input  logic              ctrl_start,
   input  logic              ctrl_stop,
   input  logic              ctrl_ack_en,
   output logic [BYTE_W-1:0] data_rdata,
   output logic              busy,
   output logic              ack_ok,
   output logic              irq,
   output logic              pins_owned,
   output logic              scl_o,
   output logic              sda_pull_o,
   input  logic              sda_i
);
   localparam int HALF = CLK_HZ / (2 * SCL_HZ);

   generate
      if (HALF < 2) begin : g_bad_rate
         $error("twi_byte_engine: CLK_HZ must be at least 4*SCL_HZ");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("twi_byte_engine: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic owned, accept, load, tick, sda_s, pull, scl_lvl;

   assign owned  = (pin_mode == PINSEL_ON);
   assign load   = owned && data_we && !busy;
   assign accept = owned && ctrl_we && !busy &&
                   (ctrl_cmd == OP_SEND || ctrl_cmd == OP_FETCH);

   twi_eng_tick #(.HALF(HALF)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(accept), .tick(tick)
   );

   twi_eng_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
   );

   twi_eng_seq u_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .accept(accept),
      .load(load), .load_byte(data_wdata),
      .cmd_rx(ctrl_cmd == OP_FETCH), .cmd_start(ctrl_start),
      .cmd_stop(ctrl_stop), .cmd_ack_en(ctrl_ack_en),
      .sda_in(sda_s), .busy(busy), .irq(irq), .ack_ok(ack_ok),
      .byte_q(data_rdata), .sda_pull(pull), .scl_lvl(scl_lvl)
   );

   assign pins_owned = owned;
   assign scl_o      = owned ? scl_lvl : 1'b1;
   assign sda_pull_o = owned && pull;

   // R11
   no_start_unowned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pins_owned && !$past(busy)) |-> !busy);
endmodule

// File: tb/tb_twi_byte_engine.sv
module tb_twi_byte_engine;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 4;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [1:0] pin_mode = 2'b01;
   logic       data_we = 1'b0, ctrl_we = 1'b0;
   logic [7:0] data_wdata = '0;
   logic [1:0] ctrl_cmd = '0;
   logic       ctrl_start = 1'b0, ctrl_stop = 1'b0, ctrl_ack_en = 1'b0;
   logic [7:0] data_rdata;
   logic       busy, ack_ok, irq, pins_owned, scl, sda_pull;
   logic       slv_pull = 1'b0;
   wire        sda_line = !(sda_pull || slv_pull);

   int n_chk = 0, n_bad = 0, cyc = 0;

   twi_byte_engine #(.CLK_HZ(800), .SCL_HZ(100), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .data_we(data_we),
      .data_wdata(data_wdata), .ctrl_we(ctrl_we), .ctrl_cmd(ctrl_cmd),
      .ctrl_start(ctrl_start), .ctrl_stop(ctrl_stop), .ctrl_ack_en(ctrl_ack_en),
      .data_rdata(data_rdata), .busy(busy), .ack_ok(ack_ok), .irq(irq),
      .pins_owned(pins_owned), .scl_o(scl), .sda_pull_o(sda_pull), .sda_i(sda_line)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // bus-level slave model
   int         s_cnt = 0, n_start = 0, n_stop = 0;
   logic       s_armed = 1'b0, s_rx = 1'b0, s_ack = 1'b0, m_ack_bit = 1'b1;
   logic [7:0] s_got = '0, s_tx = '0;

   always @(negedge sda_line) if (scl) begin n_start++; s_cnt = 0; s_armed = 1'b1; end
   always @(posedge sda_line) if (scl) begin n_stop++; s_armed = 1'b0; end
   always @(posedge scl) if (s_armed) begin
      if (s_cnt < 8) s_got = {s_got[6:0], sda_line};
      else if (s_cnt == 8) m_ack_bit = sda_line;
      s_cnt++;
   end
   always @(negedge scl) begin
      if (!s_armed) slv_pull = 1'b0;
      else if (!s_rx) slv_pull = (s_cnt == 8) && s_ack;
      else slv_pull = (s_cnt < 8) ? !s_tx[7 - s_cnt] : 1'b0;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic arm(input bit st, input bit rx, input bit ack, input logic [7:0] tx);
      s_armed = !st; s_cnt = 0; s_rx = rx; s_ack = ack; s_tx = tx; m_ack_bit = 1'b1;
   endtask

   task automatic issue(input logic [1:0] cmd, input bit st, input bit sp, input bit ae);
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_cmd = cmd; ctrl_start = st; ctrl_stop = sp; ctrl_ack_en = ae;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic load_byte(input logic [7:0] b);
      @(negedge clk); data_we = 1'b1; data_wdata = b;
      @(negedge clk); data_we = 1'b0;
   endtask

   // counts busy samples starting at the current negedge, then checks irq
   task automatic finish(input int already, input bit st, input bit sp, input string req);
      int n = already;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      chk(n == (18 + 3*st + 3*sp) * HALF, "R7", "busy length", n, (18 + 3*st + 3*sp) * HALF);
      chk(irq == 1'b1, "R6", "irq at busy fall", irq, 1);
      @(negedge clk);
      chk(irq == 1'b0, "R6", "irq single cycle", irq, 0);
      for (int i = 0; i < 3; i++) begin
         chk(scl == 1'b1, "R9", {req, " clock rests high"}, scl, 1);
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk(busy == 0 && irq == 0 && ack_ok == 0, "R1", "status after reset", {busy, irq, ack_ok}, 0);
      chk(scl == 1 && sda_pull == 0, "R1", "pins after reset", {scl, sda_pull}, 2);
      chk(data_rdata == 8'h00, "R1", "byte after reset", data_rdata, 0);
   endtask

   task automatic t_tx(input logic [7:0] b, input bit st, input bit sp, input bit give);
      int s0 = n_start, p0 = n_stop;
      arm(st, 1'b0, give, 8'h00);
      load_byte(b);
      issue(2'b01, st, sp, 1'b0);
      finish(0, st, sp, "R2");
      chk(s_got == b, "R2", "byte seen by slave", s_got, b);
      chk(ack_ok == give, "R3", "ack status", ack_ok, give);
      chk(data_rdata == b, "R2", "byte register after send", data_rdata, b);
      chk(n_start - s0 == int'(st), "R8", "start count", n_start - s0, st);
      chk(n_stop - p0 == int'(sp), "R8", "stop count", n_stop - p0, sp);
   endtask

   task automatic t_rx(input logic [7:0] b, input bit st, input bit sp, input bit ae);
      int s0 = n_start, p0 = n_stop;
      arm(st, 1'b1, 1'b0, b);
      issue(2'b10, st, sp, ae);
      finish(0, st, sp, "R4");
      chk(data_rdata == b, "R4", "received byte", data_rdata, b);
      chk(m_ack_bit == !ae, "R5", "ninth bit level", m_ack_bit, !ae);
      chk(n_start - s0 == int'(st), "R8", "start count rx", n_start - s0, st);
      chk(n_stop - p0 == int'(sp), "R2", "no stray edges rx", n_stop - p0, sp);
   endtask

   task automatic t_bad_cmd();
      for (int c = 0; c < 4; c += 3) begin
         issue(2'(c), 1'b1, 1'b1, 1'b0);
         for (int i = 0; i < 2*HALF; i++) begin
            chk(busy == 0 && scl == 1, "R10", "reserved code ignored", {busy, scl}, 1);
            @(negedge clk);
         end
      end
   endtask

   task automatic t_busy_ignore();
      arm(1'b1, 1'b0, 1'b1, 8'h00);
      load_byte(8'h81);
      issue(2'b01, 1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 5; i++) @(negedge clk);
      data_we = 1'b1; data_wdata = 8'hFF; ctrl_we = 1'b1; ctrl_cmd = 2'b10; ctrl_start = 1'b0;
      @(negedge clk);
      data_we = 1'b0; ctrl_we = 1'b0;
      finish(6, 1'b1, 1'b1, "R10");
      chk(s_got == 8'h81, "R10", "byte during busy writes", s_got, 8'h81);
      chk(data_rdata == 8'h81, "R10", "load while busy ignored", data_rdata, 8'h81);
   endtask

   task automatic t_unowned();
      logic [7:0] keep = data_rdata;
      pin_mode = 2'b00;
      load_byte(8'h17);
      issue(2'b01, 1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 2*HALF; i++) begin
         chk(busy == 0 && pins_owned == 0 && scl == 1 && sda_pull == 0, "R11",
             "pins released", {busy, pins_owned, scl, sda_pull}, 2);
         @(negedge clk);
      end
      pin_mode = 2'b11;
      @(negedge clk);
      chk(pins_owned == 0, "R11", "mode 11 not owned", pins_owned, 0);
      pin_mode = 2'b01;
      @(negedge clk);
      chk(data_rdata == keep, "R11", "load ignored when unowned", data_rdata, keep);
   endtask

   task automatic t_same_cycle();
      arm(1'b1, 1'b0, 1'b1, 8'h00);
      @(negedge clk);
      data_we = 1'b1; data_wdata = 8'h6B;
      ctrl_we = 1'b1; ctrl_cmd = 2'b01; ctrl_start = 1'b1; ctrl_stop = 1'b1;
      @(negedge clk);
      data_we = 1'b0; ctrl_we = 1'b0;
      finish(0, 1'b1, 1'b1, "R12");
      chk(s_got == 8'h6B, "R12", "same-cycle load sent", s_got, 8'h6B);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tx(8'hA5, 1'b1, 1'b1, 1'b1);
      t_tx(8'h3C, 1'b1, 1'b0, 1'b0);
      t_rx(8'hC9, 1'b1, 1'b1, 1'b1);
      t_rx(8'h5E, 1'b0, 1'b0, 1'b0);
      t_rx(8'h02, 1'b1, 1'b1, 1'b0);
      t_bad_cmd();
      t_busy_ignore();
      t_unowned();
      t_same_cycle();
      summary();
   end
endmodule